// File: doc/BRIEF.md
# Register-Controlled Variable-Length SPI Master

This block is an SPI master that software drives through a small register file on a simple write/read bus. Software places up to 40 bits of transmit data in two registers, picks a transfer length in bits and sets a start bit. The block then shifts the data out MSB-first on MOSI in SPI mode 0 and collects MISO into a 40-bit receive register, which software reads back from two registers once the status register shows completion.

Software picks how the transmit word is laid out. In raw mode the first bit sent is always bit 39. In aligned mode the first bit sent is bit LENGTH-1, so short words can sit in the low bits. A chip-select register picks one of several slaves with a one-hot code. In normal mode the block asserts the selected line around each transfer. In manual mode the lines copy the select field directly, so software can hold a slave selected across several transfers. A loopback switch feeds the block's own MOSI into its capture path instead of the MISO pin.

The register bus has no back-pressure. A write with `bus_we` high is taken on that clock edge. Reads are combinational from `bus_addr`, so they are always ready. The serial side has no handshake: software learns that a transfer is finished by polling the status register.

Top module: `spi_regmaster`

## Requirements
- R1: Byte offsets are control 0x00, status 0x04, transmit upper 0x08 (bits 7:0 hold data bits 39:32), transmit lower 0x0C (data bits 31:0), receive upper 0x10, receive lower 0x14, chip-select 0x18 and loopback 0x1C. The control register reads back its length field in bits [15:8] and reads bit 0 as 0. The transmit registers read back what was written.
- R2: Writing control with bit 0 set, while the block is idle, starts a transfer of the length in bits [15:8] and clears status bit 0 (DONE). DONE reads 1 after the transfer has finished.
- R3: SCLK idles low. The bits leave MSB-first on MOSI, and MOSI changes only while SCLK is low. A transfer of length N gives exactly N rising SCLK edges, each high or low phase lasting HALF_DIV clock cycles.
- R4: With status bit 1 at 0 (raw), the transmitted bits are data bits 39, 38, … down to 40-N.
- R5: With status bit 1 at 1 (aligned), the transmitted bits are data bits N-1 down to 0.
- R6: MISO is sampled on each rising SCLK edge and shifted in MSB-first. After a transfer of N bits, receive bits N-1:0 hold the bits in arrival order (first bit at N-1) and the higher bits read 0.
- R7: With loopback bit 0 set, the captured bits are the block's own MOSI bits and the MISO pin is ignored.
- R8: In normal mode (chip-select bit 16 = 0) the line chosen by the one-hot select field (bit k selects slave k) is low from at least half an SCLK period before the first rising edge until at least half a period after the last falling edge. All other lines stay high, and DONE never reads 1 while a line is still low.
- R9: In manual mode (chip-select bit 16 = 1) the active-low CS outputs are the inverted select field at all times, whether or not a transfer is running.
- R10: A start with length 0 sets DONE at once, gives no SCLK edge and does not assert CS.
- R11: A length above 40 is treated as 40.
- R12: A control write while a transfer is running is ignored entirely. The running transfer keeps its length and the stored length field is unchanged.
- R13: Writing status bit 1 sets the data mode. DONE cannot be written by software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe, taken on the clock edge |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low slave selects |

## Verification
The shift engine is tried with loopback words in raw and aligned layout at short lengths. Raw and aligned runs tell apart the two start positions in the transmit word. A full 40-bit run against a slave model sends different patterns on MOSI and MISO, so swapped or reversed bit order, an off-by-one edge count, or MOSI leaking into the capture path each show up as a mismatch. Lengths 0 and 200 test the two ends of the length range. A second start issued mid-transfer, manual chip-select and a status write test the control side, using edge counts, CS timing measured on the pins and register readback.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int BUS_AW = 5;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFF_CTRL    = 5'h00;
  localparam logic [BUS_AW-1:0] OFF_STATUS  = 5'h04;
  localparam logic [BUS_AW-1:0] OFF_TX_HI   = 5'h08;
  localparam logic [BUS_AW-1:0] OFF_TX_LO   = 5'h0C;
  localparam logic [BUS_AW-1:0] OFF_RX_HI   = 5'h10;
  localparam logic [BUS_AW-1:0] OFF_RX_LO   = 5'h14;
  localparam logic [BUS_AW-1:0] OFF_CSEL    = 5'h18;
  localparam logic [BUS_AW-1:0] OFF_LOOP    = 5'h1C;

  localparam int CSEL_MANUAL_BIT = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_HOLD
  } spim_state_e;

endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int DATA_W = 40,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  len_in,
  input  logic              aligned,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              miso_in,
  input  logic              tick,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data
);

  spim_state_e       state_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [CNT_W-1:0]  len_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic              sclk_q;
  logic              done_q;

  logic [CNT_W-1:0]  shift_amt;
  logic [DATA_W-1:0] tx_load;
  logic              accept;

  assign accept    = start && (state_q == ST_IDLE);
  assign shift_amt = CNT_W'(DATA_W) - len_in;
  assign tx_load   = aligned ? (tx_data << shift_amt) : tx_data;

  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign sclk    = sclk_q;
  assign mosi    = tx_q[DATA_W-1];
  assign rx_data = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      len_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            rx_q     <= '0;
            bitcnt_q <= '0;
            len_q    <= len_in;
            tx_q     <= tx_load;
            if (len_in == '0) begin
              done_q <= 1'b1;
            end else begin
              done_q  <= 1'b0;
              state_q <= ST_SETUP;
            end
          end
        end
        ST_SETUP, ST_LOW: begin
          if (tick) begin
            sclk_q  <= 1'b1;
            rx_q    <= {rx_q[DATA_W-2:0], miso_in};
            state_q <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclk_q   <= 1'b0;
            bitcnt_q <= bitcnt_q + CNT_W'(1);
            if (bitcnt_q + CNT_W'(1) == len_q) begin
              state_q <= ST_HOLD;
            end else begin
              tx_q    <= {tx_q[DATA_W-2:0], 1'b0};
              state_q <= ST_LOW;
            end
          end
        end
        ST_HOLD: begin
          if (tick) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sclk_q); // R3

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(tx_q[DATA_W-1])); // R3

  AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && len_in == '0) |=> (done_q && state_q == ST_IDLE && !sclk_q)); // R10

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && len_in != '0) |=> !done_q); // R2

  AST_BITCNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bitcnt_q <= len_q && len_q <= CNT_W'(DATA_W))); // R11

endmodule

// File: rtl/spim_csctl.sv
module spim_csctl #(
  parameter int NUM_CS = 4
) (
  input  logic [NUM_CS-1:0] sel,
  input  logic              manual,
  input  logic              active,
  output logic [NUM_CS-1:0] cs_n
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    always_comb begin
      if (manual) begin
        cs_n[i] = ~sel[i];
      end else begin
        cs_n[i] = ~(sel[i] && active);
      end
    end
  end

endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
  import spim_pkg::*;
#(
  parameter int DATA_W   = 40,
  parameter int NUM_CS   = 4,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int HI_W  = DATA_W - 32;

  logic [7:0]        len_raw_q;
  logic              mode_q;
  logic [DATA_W-1:0] tx_q;
  logic [NUM_CS-1:0] sel_q;
  logic              manual_q;
  logic              loop_q;

  logic              busy;
  logic              done;
  logic              tick;
  logic              mosi_int;
  logic              miso_eff;
  logic [DATA_W-1:0] rx_data;
  logic              ctrl_wr;
  logic              start;
  logic [7:0]        len_new;
  logic [CNT_W-1:0]  len_clamped;
  logic              unused_bits;

  assign unused_bits = ^bus_wdata;

  assign ctrl_wr     = bus_we && (bus_addr == OFF_CTRL) && !busy;
  assign start       = ctrl_wr && bus_wdata[0];
  assign len_new     = bus_wdata[15:8];
  assign len_clamped = (len_new > 8'(DATA_W)) ? CNT_W'(DATA_W) : len_new[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_raw_q <= '0;
      mode_q    <= 1'b0;
      tx_q      <= '0;
      sel_q     <= NUM_CS'(1);
      manual_q  <= 1'b0;
      loop_q    <= 1'b0;
    end else if (bus_we) begin
      unique case (bus_addr)
        OFF_CTRL:   if (!busy) len_raw_q <= len_new;
        OFF_STATUS: mode_q <= bus_wdata[1];
        OFF_TX_HI:  tx_q[DATA_W-1:32] <= bus_wdata[HI_W-1:0];
        OFF_TX_LO:  tx_q[31:0] <= bus_wdata;
        OFF_CSEL: begin
          sel_q    <= bus_wdata[NUM_CS-1:0];
          manual_q <= bus_wdata[CSEL_MANUAL_BIT];
        end
        OFF_LOOP:   loop_q <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFF_CTRL:   bus_rdata = 32'(len_raw_q) << 8;
      OFF_STATUS: bus_rdata = 32'({mode_q, done});
      OFF_TX_HI:  bus_rdata = 32'(tx_q[DATA_W-1:32]);
      OFF_TX_LO:  bus_rdata = tx_q[31:0];
      OFF_RX_HI:  bus_rdata = 32'(rx_data[DATA_W-1:32]);
      OFF_RX_LO:  bus_rdata = rx_data[31:0];
      OFF_CSEL:   bus_rdata = 32'(sel_q) | (32'(manual_q) << CSEL_MANUAL_BIT);
      OFF_LOOP:   bus_rdata = 32'(loop_q);
      default:    bus_rdata = '0;
    endcase
  end

  assign miso_eff = loop_q ? mosi_int : spi_miso;
  assign spi_mosi = mosi_int;

  spim_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .tick  (tick)
  );

  spim_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .len_in  (len_clamped),
    .aligned (mode_q),
    .tx_data (tx_q),
    .miso_in (miso_eff),
    .tick    (tick),
    .busy    (busy),
    .done    (done),
    .sclk    (spi_sclk),
    .mosi    (mosi_int),
    .rx_data (rx_data)
  );

  spim_csctl #(.NUM_CS(NUM_CS)) u_csctl (
    .sel    (sel_q),
    .manual (manual_q),
    .active (busy),
    .cs_n   (spi_cs_n)
  );

  AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_q && done) |-> (&spi_cs_n)); // R8

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_CTRL && busy) |=> $stable(len_raw_q)); // R12

  AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (len_clamped <= CNT_W'(DATA_W))); // R11

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && !manual_q && $onehot(sel_q)) |-> !(&spi_cs_n)); // R8

endmodule

// File: tb/sim_spi_regmaster.sv
module sim_spi_regmaster;

  localparam int    NUM_CS   = 4;
  localparam int    HALF_DIV = 2;
  localparam realtime HALF_NS = HALF_DIV * 20.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk;
  logic        spi_mosi;
  logic        spi_miso;
  logic [NUM_CS-1:0] spi_cs_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_regmaster #(.DATA_W(40), .NUM_CS(NUM_CS), .HALF_DIV(HALF_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // Pin monitors
  int rise_cnt = 0, fall_cnt = 0, cs_fall_cnt = 0;
  int cs_bad = 0, lead_bad = 0, lag_bad = 0, seen_fall_seq = 0;
  logic [39:0] cap = '0;
  logic [NUM_CS-1:0] cs_exp = 4'b1110;
  realtime t_cs_fall = 0, t_last_fall = 0;
  logic cs_any;
  assign cs_any = ~&spi_cs_n;

  logic [39:0] slave_pat = '0;
  int fall_base = 0;
  int slv_idx;
  assign slv_idx  = fall_cnt - fall_base;
  assign spi_miso = (slv_idx >= 0 && slv_idx < 40) ? slave_pat[39 - slv_idx] : 1'b0;

  always @(posedge cs_any) begin
    cs_fall_cnt++;
    t_cs_fall = $realtime;
  end
  always @(negedge cs_any) begin
    if ($realtime - t_last_fall < HALF_NS) lag_bad++;
  end
  always @(posedge spi_sclk) begin
    rise_cnt++;
    cap = {cap[38:0], spi_mosi};
    if (spi_cs_n !== cs_exp) cs_bad++;
    if (cs_fall_cnt != seen_fall_seq) begin
      if ($realtime - t_cs_fall < HALF_NS) lead_bad++;
      seen_fall_seq = cs_fall_cnt;
    end
  end
  always @(negedge spi_sclk) begin
    fall_cnt++;
    t_last_fall = $realtime;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      bus_read(5'h04, s);
      if (s[0]) begin
        check({req, " done with CS released"}, 64'(spi_cs_n), 64'(cs_exp == 4'b1011 ? 4'b1011 : 4'hF));
        return;
      end
    end
    check({req, " done timeout"}, 0, 1);
  endtask

  task automatic read_rx(output logic [39:0] rx);
    logic [31:0] hi, lo;
    bus_read(5'h10, hi);
    bus_read(5'h14, lo);
    rx = {hi[7:0], lo};
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_read(5'h04, d);
    check("R2 reset status", 64'(d), 0);
    check("R8 reset cs_n", 64'(spi_cs_n), 64'hF);
    check("R3 reset sclk", 64'(spi_sclk), 0);
    bus_read(5'h14, d);
    check("R6 reset rx low", 64'(d), 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    bus_write(5'h08, 32'h0000_00C3);
    bus_write(5'h0C, 32'h1357_9BDF);
    bus_read(5'h08, d); check("R1 tx upper readback", 64'(d), 64'hC3);
    bus_read(5'h0C, d); check("R1 tx lower readback", 64'(d), 64'h1357_9BDF);
    bus_write(5'h1C, 32'h1);
    bus_read(5'h1C, d); check("R1 loop readback", 64'(d), 1);
    bus_write(5'h1C, 32'h0);
  endtask

  task automatic t_raw_loop;
    logic [39:0] rx;
    int r0 = rise_cnt;
    bus_write(5'h04, 32'h0);
    bus_write(5'h1C, 32'h1);
    bus_write(5'h08, 32'hA5);
    bus_write(5'h0C, 32'h0000_00FF);
    bus_write(5'h00, 32'h0000_0801);
    wait_done("R2 raw");
    read_rx(rx);
    check("R4 R7 raw loopback rx", 64'(rx), 64'hA5);
    check("R3 raw edge count", 64'(rise_cnt - r0), 8);
    check("R4 raw mosi bits", 64'(cap[7:0]), 64'hA5);
  endtask

  task automatic t_aligned_loop;
    logic [39:0] rx;
    logic [31:0] d;
    int r0 = rise_cnt;
    bus_write(5'h04, 32'h2);
    bus_read(5'h04, d);
    check("R13 mode bit set", 64'(d[1]), 1);
    bus_write(5'h08, 32'h77);
    bus_write(5'h0C, 32'h0000_0ABC);
    bus_write(5'h00, 32'h0000_0C01);
    wait_done("R2 aligned");
    read_rx(rx);
    check("R5 R7 aligned loopback rx", 64'(rx), 64'hABC);
    check("R5 aligned mosi bits", 64'(cap[11:0]), 64'hABC);
    check("R3 aligned edge count", 64'(rise_cnt - r0), 12);
    bus_read(5'h00, d);
    check("R1 ctrl readback", 64'(d), 64'h0C00);
  endtask

  task automatic t_external40;
    logic [39:0] rx;
    logic [31:0] d;
    int r0 = rise_cnt, cb = cs_bad, lb = lead_bad, gb = lag_bad;
    bus_write(5'h04, 32'h0);
    bus_write(5'h1C, 32'h0);
    bus_write(5'h08, 32'hC3);
    bus_write(5'h0C, 32'hDEAD_BEEF);
    slave_pat = 40'h5A_1234_5678;
    fall_base = fall_cnt;
    bus_write(5'h00, 32'h0000_2801);
    bus_read(5'h04, d);
    check("R2 done cleared on start", 64'(d[0]), 0);
    wait_done("R8 external");
    read_rx(rx);
    check("R6 external rx", 64'(rx), 64'h5A_1234_5678);
    bus_read(5'h10, d);
    check("R6 rx upper split", 64'(d), 64'h5A);
    check("R4 external mosi bits", 64'(cap), 64'hC3_DEAD_BEEF);
    check("R3 external edge count", 64'(rise_cnt - r0), 40);
    check("R8 cs low on edges", 64'(cs_bad - cb), 0);
    check("R8 cs lead", 64'(lead_bad - lb), 0);
    check("R8 cs lag", 64'(lag_bad - gb), 0);
  endtask

  task automatic t_zero_len;
    logic [31:0] d;
    int r0 = rise_cnt, c0 = cs_fall_cnt;
    bus_write(5'h00, 32'h0000_0001);
    bus_read(5'h04, d);
    check("R10 zero len done", 64'(d[0]), 1);
    repeat (10) @(negedge clk);
    check("R10 zero len no sclk", 64'(rise_cnt - r0), 0);
    check("R10 zero len no cs", 64'(cs_fall_cnt - c0), 0);
  endtask

  task automatic t_clamp;
    logic [39:0] rx;
    int r0 = rise_cnt;
    slave_pat = 40'h96_0F0F_3C3C;
    fall_base = fall_cnt;
    bus_write(5'h00, 32'h0000_C801);
    wait_done("R11 clamp");
    read_rx(rx);
    check("R11 clamp edge count", 64'(rise_cnt - r0), 40);
    check("R11 clamp rx", 64'(rx), 64'h96_0F0F_3C3C);
  endtask

  task automatic t_busy_start;
    logic [39:0] rx;
    logic [31:0] d;
    int r0 = rise_cnt;
    bus_write(5'h1C, 32'h1);
    bus_write(5'h08, 32'hFF);
    bus_write(5'h0C, 32'h0);
    bus_write(5'h00, 32'h0000_0801);
    repeat (6) @(negedge clk);
    bus_write(5'h00, 32'h0000_1001);
    bus_read(5'h00, d);
    check("R12 length kept", 64'(d), 64'h0800);
    wait_done("R12 busy");
    read_rx(rx);
    check("R12 rx of first transfer", 64'(rx), 64'hFF);
    check("R12 edge count", 64'(rise_cnt - r0), 8);
  endtask

  task automatic t_manual;
    int r0 = rise_cnt, cb = cs_bad;
    bus_write(5'h18, 32'h0001_0004);
    cs_exp = 4'b1011;
    check("R9 manual cs copy", 64'(spi_cs_n), 64'hB);
    bus_write(5'h00, 32'h0000_0401);
    wait_done("R9 manual");
    check("R9 cs held after done", 64'(spi_cs_n), 64'hB);
    check("R9 cs during transfer", 64'(cs_bad - cb), 0);
    check("R9 edge count", 64'(rise_cnt - r0), 4);
    bus_write(5'h18, 32'h0000_0001);
    cs_exp = 4'b1110;
    check("R8 normal idle cs", 64'(spi_cs_n), 64'hF);
  endtask

  task automatic t_status_write;
    logic [31:0] d;
    bus_write(5'h04, 32'h0);
    bus_read(5'h04, d);
    check("R13 done not writable", 64'(d), 64'h1);
    bus_write(5'h04, 32'h3);
    bus_read(5'h04, d);
    check("R13 mode write", 64'(d), 64'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_raw_loop();
    t_aligned_loop();
    t_external40();
    t_zero_len();
    t_clamp();
    t_busy_start();
    t_manual();
    t_status_write();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule